// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block keeps one pending bit for every architectural register of an in-order, single-issue core, so that decode can detect read-after-write hazards. A register is named by a register-file kind (integer, floating-point, condition field, special) together with a register number. The integer file needs 128 entries, so every file is given 128 entries.

Each cycle, three decoded register lists arrive as slots with a valid bit, a file code and an index. The issue side lists the destination registers of the instruction that is issuing, and these become pending at the next clock edge. The writeback side lists the registers that are written in that cycle, and these stop being pending. Writeback has fewer slots than issue, so a register may stay pending for extra cycles. The decode side lists the source registers of the next instruction and gets back a combinational stall flag in the same cycle.

A source that matches any pending register stalls decode, however many read ports are free. A count of the pending registers is also output.

Top module: `reg_sb`

## Requirements
- R1: A valid destination slot marks its register pending from the next clock edge. A register that is listed twice, or is already pending, is counted once.
- R2: `stall_o` is high in the same cycle whenever any valid source slot names a pending register, even when the other source slots are unused. A destination issued in the current cycle does not stall a source in that same cycle.
- R3: A valid writeback slot clears exactly its register at the next edge and leaves every other register unchanged.
- R4: When the same register is both issued and written back in one cycle, it remains pending.
- R5: The file code (0 integer, 1 floating-point, 2 condition field, 3 special) is part of the identity. The same index in another file does not match.
- R6: Indices 0 to 127 are tracked in each file, including index 127 of the integer file.
- R7: Slots whose valid bit is 0 have no effect, whatever their file and index fields hold.
- R8: When `rst_ni` is low, all pending bits clear at once, so the count is 0 and `stall_o` is 0.
- R9: `pend_cnt_o` always equals the number of pending registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dst_vld_i | input | N_DST | Destination slot valid |
| dst_file_i | input | N_DST*2 | Destination file code per slot |
| dst_idx_i | input | N_DST*IDX_W | Destination index per slot |
| src_vld_i | input | N_SRC | Source slot valid |
| src_file_i | input | N_SRC*2 | Source file code per slot |
| src_idx_i | input | N_SRC*IDX_W | Source index per slot |
| ret_vld_i | input | N_RET | Writeback slot valid |
| ret_file_i | input | N_RET*2 | Writeback file code per slot |
| ret_idx_i | input | N_RET*IDX_W | Writeback index per slot |
| stall_o | output | 1 | Read-after-write hazard in this cycle |
| pend_cnt_o | output | CNT_W | Number of pending registers |

## Verification
The hardest case to produce is an issue and a writeback of the same register in one cycle while other registers are still pending. This exercises both the set-wins rule and the rule that unrelated registers stay untouched. Directed steps set up this collision explicitly.

A random phase then draws indices from a small pool, plus index 127. This makes overlaps between issue, writeback and source lists frequent. The bench compares the stall flag and the count against an associative-array model on every clock. A reset in the middle of the run checks that clearing is immediate.

// File: rtl/reg_sb_pkg.sv
package reg_sb_pkg;
  localparam int unsigned RF_W = 2;
  typedef enum logic [RF_W-1:0] {
    RF_INT = 2'd0,
    RF_FP  = 2'd1,
    RF_CND = 2'd2,
    RF_SPR = 2'd3
  } rf_kind_e;
endpackage

// File: rtl/sb_slot_dec.sv
module sb_slot_dec
  import reg_sb_pkg::*;
#(
  parameter int unsigned N_SLOT = 2,
  parameter int unsigned IDX_W  = 7,
  localparam int unsigned AW     = RF_W + IDX_W,
  localparam int unsigned N_BITS = 1 << AW
) (
  input  logic [N_SLOT-1:0]            vld_i,
  input  logic [N_SLOT-1:0][RF_W-1:0]  file_i,
  input  logic [N_SLOT-1:0][IDX_W-1:0] idx_i,
  output logic [N_BITS-1:0]            vec_o
);
  logic [N_SLOT-1:0][N_BITS-1:0] hot;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic [AW-1:0] key;
    assign key    = {file_i[s], idx_i[s]};
    assign hot[s] = vld_i[s] ? (N_BITS'(1) << key) : '0;
  end

  always_comb begin
    vec_o = '0;
    for (int s = 0; s < N_SLOT; s++) vec_o = vec_o | hot[s];
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int unsigned N_BITS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] set_i,
  input  logic [N_BITS-1:0] clr_i,
  output logic [N_BITS-1:0] pend_o
);
  logic [N_BITS-1:0] pend_q;

  // clear first, then set: a new issue overrides a retiring write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R1 R4
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3
  clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R3
  untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(set_i | clr_i)) == ($past(pend_q) & ~$past(set_i | clr_i))));

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) rst_clear_chk: assert (pend_q == '0);
  end
endmodule

// File: rtl/sb_popcnt.sv
module sb_popcnt #(
  parameter int unsigned N_BITS = 512,
  localparam int unsigned CNT_W = $clog2(N_BITS + 1)
) (
  input  logic [N_BITS-1:0] vec_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_BITS; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/reg_sb.sv
module reg_sb
  import reg_sb_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned N_DST = 2,
  parameter int unsigned N_SRC = 3,
  parameter int unsigned N_RET = 1,
  localparam int unsigned N_BITS = 1 << (RF_W + IDX_W),
  localparam int unsigned CNT_W  = $clog2(N_BITS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_DST-1:0]            dst_vld_i,
  input  logic [N_DST-1:0][RF_W-1:0]  dst_file_i,
  input  logic [N_DST-1:0][IDX_W-1:0] dst_idx_i,
  input  logic [N_SRC-1:0]            src_vld_i,
  input  logic [N_SRC-1:0][RF_W-1:0]  src_file_i,
  input  logic [N_SRC-1:0][IDX_W-1:0] src_idx_i,
  input  logic [N_RET-1:0]            ret_vld_i,
  input  logic [N_RET-1:0][RF_W-1:0]  ret_file_i,
  input  logic [N_RET-1:0][IDX_W-1:0] ret_idx_i,
  output logic                        stall_o,
  output logic [CNT_W-1:0]            pend_cnt_o
);
  logic [N_BITS-1:0] set_vec, clr_vec, src_vec, pend;

  sb_slot_dec #(.N_SLOT(N_DST), .IDX_W(IDX_W)) u_dst_dec (
    .vld_i(dst_vld_i), .file_i(dst_file_i), .idx_i(dst_idx_i), .vec_o(set_vec));

  sb_slot_dec #(.N_SLOT(N_RET), .IDX_W(IDX_W)) u_ret_dec (
    .vld_i(ret_vld_i), .file_i(ret_file_i), .idx_i(ret_idx_i), .vec_o(clr_vec));

  sb_slot_dec #(.N_SLOT(N_SRC), .IDX_W(IDX_W)) u_src_dec (
    .vld_i(src_vld_i), .file_i(src_file_i), .idx_i(src_idx_i), .vec_o(src_vec));

  sb_store #(.N_BITS(N_BITS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend));

  sb_popcnt #(.N_BITS(N_BITS)) u_cnt (.vec_i(pend), .cnt_o(pend_cnt_o));

  // stall ignores free ports: any overlap is a hazard
  assign stall_o = |(src_vec & pend);

  // R9
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt_o == CNT_W'($countones(pend)));

  // R7
  stall_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (src_vld_i != '0));

  // R7
  dst_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_vec) <= $countones(dst_vld_i));

  // R1
  cnt_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_cnt_o <= $past(pend_cnt_o) + CNT_W'($countones($past(dst_vld_i)))));
endmodule

// File: tb/sim_reg_sb.sv
`timescale 1ns/1ps
module sim_reg_sb;
  localparam int IDX_W = 7;
  localparam int NR    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]            dst_vld;
  logic [1:0][1:0]       dst_file;
  logic [1:0][IDX_W-1:0] dst_idx;
  logic [2:0]            src_vld;
  logic [2:0][1:0]       src_file;
  logic [2:0][IDX_W-1:0] src_idx;
  logic [0:0]            ret_vld;
  logic [0:0][1:0]       ret_file;
  logic [0:0][IDX_W-1:0] ret_idx;
  logic       stall;
  logic [9:0] cnt;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit model[int];

  always #4 clk = ~clk;

  reg_sb #(.IDX_W(IDX_W), .N_DST(2), .N_SRC(3), .N_RET(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .dst_vld_i(dst_vld), .dst_file_i(dst_file), .dst_idx_i(dst_idx),
    .src_vld_i(src_vld), .src_file_i(src_file), .src_idx_i(src_idx),
    .ret_vld_i(ret_vld), .ret_file_i(ret_file), .ret_idx_i(ret_idx),
    .stall_o(stall), .pend_cnt_o(cnt));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    dst_vld = '0; src_vld = '0; ret_vld = '0;
    dst_file = '0; dst_idx = '0; src_file = '0; src_idx = '0;
    ret_file = '0; ret_idx = '0;
  endtask

  function automatic int model_stall();
    int hit = 0;
    for (int s = 0; s < 3; s++)
      if (src_vld[s] && model.exists(int'(src_file[s]) * NR + int'(src_idx[s]))) hit = 1;
    return hit;
  endfunction

  // called just after a negedge with inputs set
  task automatic step(string tag);
    #2;
    chk({tag, " stall"}, int'(stall), model_stall());
    @(posedge clk);
    if (ret_vld[0]) model.delete(int'(ret_file[0]) * NR + int'(ret_idx[0]));
    for (int s = 0; s < 2; s++)
      if (dst_vld[s]) model[int'(dst_file[s]) * NR + int'(dst_idx[s])] = 1'b1;
    #1;
    chk({tag, " count"}, int'(cnt), model.num());
    @(negedge clk);
  endtask

  task automatic query(string tag, int f, int i, int exp);
    idle();
    src_vld = 3'b010; src_file[1] = 2'(f); src_idx[1] = 7'(i);
    #2;
    chk(tag, int'(stall), exp);
    @(negedge clk);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset count", int'(cnt), 0);
    src_vld = 3'b111; #1;
    chk("R8 reset stall", int'(stall), 0);
    idle();
    rst_n = 1'b1;
    @(negedge clk);

    // R1 two destinations
    dst_vld = 2'b11; dst_file[0] = 2'd0; dst_idx[0] = 7'd1; dst_file[1] = 2'd0; dst_idx[1] = 7'd2;
    step("R1");
    chk("R1 two pending", int'(cnt), 2);
    // R1 duplicate and already pending
    idle(); dst_vld = 2'b11; dst_idx[0] = 7'd1; dst_idx[1] = 7'd1;
    step("R1 dup");
    chk("R1 no duplicate", int'(cnt), 2);

    // R2 single slot hazard with free slots
    query("R2 hazard on pending", 0, 1, 1);
    query("R2 no hazard on clean", 0, 3, 0);
    idle(); #2; chk("R2 no valid sources", int'(stall), 0); @(negedge clk);

    // R5 file identity
    query("R5 other file same index", 1, 1, 0);
    query("R5 special file same index", 3, 2, 0);

    // R6 top index
    idle(); dst_vld = 2'b01; dst_file[0] = 2'd0; dst_idx[0] = 7'd127;
    step("R6");
    query("R6 index 127 pending", 0, 127, 1);
    query("R6 index 126 clean", 0, 126, 0);

    // R3 retire one, others stay
    idle(); ret_vld = 1'b1; ret_file[0] = 2'd0; ret_idx[0] = 7'd1;
    step("R3");
    query("R3 retired clear", 0, 1, 0);
    query("R3 neighbour kept", 0, 2, 1);
    chk("R3 count", int'(cnt), 2);

    // R4 issue and retire same register
    idle(); dst_vld = 2'b01; dst_file[0] = 2'd1; dst_idx[0] = 7'd9;
    step("R4 setup");
    idle(); dst_vld = 2'b01; dst_file[0] = 2'd1; dst_idx[0] = 7'd9;
    ret_vld = 1'b1; ret_file[0] = 2'd1; ret_idx[0] = 7'd9;
    step("R4");
    query("R4 set wins", 1, 9, 1);

    // R7 invalid slots ignored
    idle(); dst_file[0] = 2'd2; dst_idx[0] = 7'd5; ret_file[0] = 2'd0; ret_idx[0] = 7'd2;
    src_file[0] = 2'd0; src_idx[0] = 7'd2;
    step("R7");
    query("R7 invalid retire kept", 0, 2, 1);
    query("R7 invalid issue absent", 2, 5, 0);

    // R2 same-cycle issue does not stall
    idle(); dst_vld = 2'b01; dst_file[0] = 2'd2; dst_idx[0] = 7'd6;
    src_vld = 3'b001; src_file[0] = 2'd2; src_idx[0] = 7'd6;
    #2; chk("R2 same-cycle issue", int'(stall), 0); #0;
    step("R2 same-cycle");
    query("R2 next-cycle hazard", 2, 6, 1);

    // R9 random traffic
    for (int n = 0; n < 400; n++) begin
      idle();
      for (int s = 0; s < 2; s++) begin
        dst_vld[s] = ($urandom_range(0, 2) == 0);
        dst_file[s] = 2'($urandom_range(0, 3));
        dst_idx[s] = ($urandom_range(0, 9) == 0) ? 7'd127 : 7'($urandom_range(0, 5));
      end
      for (int s = 0; s < 3; s++) begin
        src_vld[s] = $urandom_range(0, 1) == 1;
        src_file[s] = 2'($urandom_range(0, 3));
        src_idx[s] = 7'($urandom_range(0, 5));
      end
      ret_vld[0] = $urandom_range(0, 1) == 1;
      ret_file[0] = 2'($urandom_range(0, 3));
      ret_idx[0] = ($urandom_range(0, 9) == 0) ? 7'd127 : 7'($urandom_range(0, 5));
      step("R9 random");
    end

    // R8 reset mid-run
    idle();
    rst_n = 1'b0;
    #1;
    model.delete();
    chk("R8 mid-run count", int'(cnt), 0);
    src_vld = 3'b111; #1;
    chk("R8 mid-run stall", int'(stall), 0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    query("R8 after release", 0, 2, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule